// File: doc/BRIEF.md
# Hold-Over History Manager

This block keeps the frequency history that a timing loop falls back on when it loses its reference. Frequency-word samples arrive while the loop is locked and are folded into an accumulator as a running average. Once enough time has passed, the accumulated value is promoted to the active history. From then on the active history follows the accumulator on every clock. The exception is Hold Over mode: there the active history is frozen, because the loop is steering from it. A backup store can be written from the active history and read back into it. A flush clears the working stores and leaves the backup alone.

A build state machine has three states. BS_IDLE means the accumulator is empty. BS_BUILD means the accumulator has data and the build timer is running. BS_TRACK means the build is complete and the active history tracks the accumulator. Its transitions are:
- IDLE_TO_BUILD: the first valid sample while locked.
- BUILD_TO_TRACK: the last build tick while locked.
- ANY_TO_IDLE: a restart, caused by a flush, a restore, or a reference switch under the rebuild policy.

A separate counter measures whole hours spent in Hold Over. It saturates at its maximum and reads zero outside Hold Over. The build length and the hour length are both parameters counted in ticks, so a bench can shorten them.

Top module: `hovr_hist_mgr`

## Requirements
- R1: After reset, active_hist_o, avail_o, built_o, last_cmd_o and hours_o are all zero.
- R2: The accumulator changes only in a cycle with locked_i=1 and sample_vld_i=1 and no restart. The first sample after it is emptied is loaded as is. Each later sample s updates the accumulator a to a+((s-a)>>>AVG_SHIFT), in signed two's complement of width W.
- R3: In BS_BUILD, each cycle with locked_i=1 and tick_i=1 counts one build tick. On the BUILD_TICKS-th such tick, built_o and avail_o read 1 from the next cycle, and active_hist_o takes the accumulator value held before that edge.
- R4: In BS_TRACK, active_hist_o takes each cycle the accumulator value held before the edge. While mode_i=2'b10 (Hold Over), active_hist_o does not change except through a command or a reference switch.
- R5: A command write with cmd_i=2'b01 (save) copies active_hist_o and avail_o into the backup store.
- R6: A command write with cmd_i=2'b10 (restore) loads active_hist_o and avail_o from the backup store. It also clears built_o and empties the accumulator, so the build restarts from BS_IDLE.
- R7: A command write with cmd_i=2'b11 (flush) clears active_hist_o, avail_o and built_o, and empties the accumulator. The backup store is unchanged.
- R8: A command write with cmd_i=2'b00 changes no history. last_cmd_o shows the code of the last command write from the next cycle on.
- R9: When ref_switch_i=1 and policy_i=0, the block acts as for a flush but leaves last_cmd_o alone. When policy_i=1, a switch has no effect. If a restore or flush write falls in the same cycle as a switch, the command takes precedence.
- R10: While mode_i=2'b10, hours_o rises by one every TICKS_PER_HOUR ticks and stops at 255. In any other mode it reads 0 at once, and counting restarts from zero on the next entry into Hold Over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| locked_i | input | 1 | Loop is locked to a reference |
| sample_vld_i | input | 1 | sample_i carries a new frequency word |
| sample_i | input | W | Signed frequency-word sample |
| mode_i | input | 2 | Operating mode; 2'b10 is Hold Over |
| ref_switch_i | input | 1 | One-cycle strobe on a reference change |
| policy_i | input | 1 | Switch policy: 0 rebuild, 1 keep history |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 2 | Command code: 00 none, 01 save, 10 restore, 11 flush |
| tick_i | input | 1 | Time tick used for build and hour timing |
| active_hist_o | output | W | Active history value |
| avail_o | output | 1 | Active history holds usable data |
| built_o | output | 1 | Build procedure complete (BS_TRACK) |
| last_cmd_o | output | 2 | Last written command code |
| hours_o | output | 8 | Whole hours spent in Hold Over, saturating |

## Verification
Every history, flag and command result is due one clock after the edge that samples its stimulus, because the accumulator, the active and backup stores, the state and last_cmd_o are all single registers. The one exception is the Hold Over exit, which zeroes hours_o in the same cycle. The bench drives inputs just after the falling edge and updates its behavioural model at the rising edge from those same inputs. It compares all outputs at the next falling edge, so each result is checked exactly one cycle after its cause. The bench computes expected hours_o from the model's hour count and the mode present at compare time, which covers the same-cycle zeroing.

// File: rtl/hovr_pkg.sv
package hovr_pkg;

    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_BUILD = 2'd1,
        BS_TRACK = 2'd2
    } bstate_e;

    typedef enum logic [1:0] {
        HC_NONE    = 2'b00,
        HC_SAVE    = 2'b01,
        HC_RESTORE = 2'b10,
        HC_FLUSH   = 2'b11
    } hcmd_e;

    localparam logic [1:0] MODE_HOLD = 2'b10;

endpackage

// File: rtl/hovr_acc.sv
module hovr_acc #(
    parameter int W        = 16,
    parameter int AVG_SHIFT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         upd_i,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] acc_o,
    output logic         has_o
);

    logic [W-1:0]      acc_q;
    logic              has_q;
    logic signed [W:0] diff;
    logic signed [W:0] step;
    logic signed [W:0] nxt;

    // Running average step in one extra bit of headroom
    always_comb begin
        diff = $signed({sample_i[W-1], sample_i}) - $signed({acc_q[W-1], acc_q});
        step = diff >>> AVG_SHIFT;
        nxt  = $signed({acc_q[W-1], acc_q}) + step;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            has_q <= 1'b0;
        end else if (clear_i) begin
            acc_q <= '0;
            has_q <= 1'b0;
        end else if (upd_i) begin
            acc_q <= has_q ? nxt[W-1:0] : sample_i;
            has_q <= 1'b1;
        end
    end

    assign acc_o = acc_q;
    assign has_o = has_q;

    // The average lies between old value and sample, so it never leaves W bits
    AST_AVG_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && has_q) |-> (nxt[W] == nxt[W-1])); // R2

endmodule

// File: rtl/hovr_build_fsm.sv
module hovr_build_fsm
    import hovr_pkg::*;
#(
    parameter int BUILD_TICKS = 900
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    restart_i,
    input  logic    locked_i,
    input  logic    sample_vld_i,
    input  logic    tick_i,
    output bstate_e state_o,
    output logic    done_o
);

    localparam int CNT_W = $clog2(BUILD_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(BUILD_TICKS - 1);

    bstate_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_step;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        done_o   = 1'b0;
        cnt_step = locked_i && tick_i;
        if (restart_i) begin
            state_d = BS_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                BS_IDLE: begin
                    cnt_d = '0;
                    if (locked_i && sample_vld_i) begin
                        state_d = BS_BUILD;
                    end
                end
                BS_BUILD: begin
                    if (cnt_step) begin
                        if (cnt_q == LAST_TICK) begin
                            done_o  = 1'b1;
                            cnt_d   = '0;
                            state_d = BS_TRACK;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                BS_TRACK: begin
                    cnt_d = '0;
                end
                default: begin
                    state_d = BS_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    assign state_o = state_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_TICK); // R3

    AST_TRACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BS_TRACK && !restart_i) |=> (state_q == BS_TRACK)); // R4

endmodule

// File: rtl/hovr_hour_cnt.sv
module hovr_hour_cnt #(
    parameter int TICKS_PER_HOUR = 3600,
    parameter int HOURS_W        = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_hold_i,
    input  logic               tick_i,
    output logic [HOURS_W-1:0] hours_o
);

    localparam int TW = $clog2(TICKS_PER_HOUR + 1);
    localparam logic [TW-1:0]      LAST_T  = TW'(TICKS_PER_HOUR - 1);
    localparam logic [HOURS_W-1:0] HRS_MAX = '1;

    logic [TW-1:0]      tcnt_q;
    logic [HOURS_W-1:0] hrs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            hrs_q  <= '0;
        end else if (!in_hold_i) begin
            tcnt_q <= '0;
            hrs_q  <= '0;
        end else if (tick_i) begin
            if (tcnt_q == LAST_T) begin
                tcnt_q <= '0;
                if (hrs_q != HRS_MAX) begin
                    hrs_q <= hrs_q + 1'b1;
                end
            end else begin
                tcnt_q <= tcnt_q + 1'b1;
            end
        end
    end

    // Reads zero outside Hold Over without waiting for the register
    assign hours_o = in_hold_i ? hrs_q : '0;

    AST_HOURS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_hold_i |=> (hrs_q == '0)); // R10

    AST_HOURS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold_i && hrs_q == HRS_MAX) |=> (!in_hold_i || hrs_q == HRS_MAX)); // R10

    AST_HOURS_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold_i && hrs_q != HRS_MAX) |=> (!in_hold_i || hrs_q >= $past(hrs_q))); // R10

endmodule

// File: rtl/hovr_hist_mgr.sv
module hovr_hist_mgr
    import hovr_pkg::*;
#(
    parameter int W              = 16,
    parameter int AVG_SHIFT      = 3,
    parameter int BUILD_TICKS    = 900,
    parameter int TICKS_PER_HOUR = 3600
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         locked_i,
    input  logic         sample_vld_i,
    input  logic [W-1:0] sample_i,
    input  logic [1:0]   mode_i,
    input  logic         ref_switch_i,
    input  logic         policy_i,
    input  logic         cmd_we_i,
    input  logic [1:0]   cmd_i,
    input  logic         tick_i,
    output logic [W-1:0] active_hist_o,
    output logic         avail_o,
    output logic         built_o,
    output logic [1:0]   last_cmd_o,
    output logic [7:0]   hours_o
);

    localparam int HOURS_W = 8;

    logic         in_hold;
    logic         cmd_flush, cmd_restore, cmd_save;
    logic         sw_rebuild, do_clear, restart;
    logic         acc_upd, acc_has, build_done;
    logic [W-1:0] acc_val;
    bstate_e      bstate;

    logic [W-1:0] active_q, backup_q;
    logic         avail_q, bvalid_q;
    logic [1:0]   last_cmd_q;
    logic         track_now;

    // Command and switch decode; a command outranks a same-cycle switch
    always_comb begin
        in_hold     = (mode_i == MODE_HOLD);
        cmd_flush   = cmd_we_i && (cmd_i == HC_FLUSH);
        cmd_restore = cmd_we_i && (cmd_i == HC_RESTORE);
        cmd_save    = cmd_we_i && (cmd_i == HC_SAVE);
        sw_rebuild  = ref_switch_i && !policy_i && !cmd_flush && !cmd_restore;
        do_clear    = cmd_flush || sw_rebuild;
        restart     = do_clear || cmd_restore;
        acc_upd     = locked_i && sample_vld_i && !restart;
    end

    hovr_acc #(
        .W         (W),
        .AVG_SHIFT (AVG_SHIFT)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (restart),
        .upd_i    (acc_upd),
        .sample_i (sample_i),
        .acc_o    (acc_val),
        .has_o    (acc_has)
    );

    hovr_build_fsm #(
        .BUILD_TICKS (BUILD_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .restart_i    (restart),
        .locked_i     (locked_i),
        .sample_vld_i (sample_vld_i),
        .tick_i       (tick_i),
        .state_o      (bstate),
        .done_o       (build_done)
    );

    hovr_hour_cnt #(
        .TICKS_PER_HOUR (TICKS_PER_HOUR),
        .HOURS_W        (HOURS_W)
    ) u_hours (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_hold_i (in_hold),
        .tick_i    (tick_i),
        .hours_o   (hours_o)
    );

    // Tracking is allowed only after the build and outside Hold Over
    always_comb begin
        track_now = 1'b0;
        unique case (bstate)
            BS_IDLE:  track_now = 1'b0;
            BS_BUILD: track_now = 1'b0;
            BS_TRACK: track_now = !in_hold;
            default:  track_now = 1'b0;
        endcase
    end

    // Active history and availability
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
            avail_q  <= 1'b0;
        end else if (do_clear) begin
            active_q <= '0;
            avail_q  <= 1'b0;
        end else if (cmd_restore) begin
            active_q <= backup_q;
            avail_q  <= bvalid_q;
        end else if (build_done) begin
            active_q <= acc_val;
            avail_q  <= 1'b1;
        end else if (track_now) begin
            active_q <= acc_val;
        end
    end

    // Backup store and command readback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            backup_q   <= '0;
            bvalid_q   <= 1'b0;
            last_cmd_q <= HC_NONE;
        end else begin
            if (cmd_save) begin
                backup_q <= active_q;
                bvalid_q <= avail_q;
            end
            if (cmd_we_i) begin
                last_cmd_q <= cmd_i;
            end
        end
    end

    assign active_hist_o = active_q;
    assign avail_o       = avail_q;
    assign built_o       = (bstate == BS_TRACK);
    assign last_cmd_o    = last_cmd_q;

    AST_BUILT_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        built_o |-> avail_o); // R3

    AST_BUILT_HAS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        built_o |-> acc_has); // R2

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && !restart && !build_done) |=> $stable(active_q)); // R4

    AST_SAVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_save |=> (backup_q == $past(active_q))); // R5

    AST_RESTORE_UNBUILT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_restore |=> (!built_o && active_q == $past(backup_q))); // R6

    AST_FLUSH_KEEPS_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_flush |=> ($stable(backup_q) && active_q == '0 && !avail_q)); // R7

    AST_LAST_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we_i |=> (last_cmd_o == $past(cmd_i))); // R8

    AST_SWITCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_switch_i && policy_i && !cmd_we_i && !in_hold && bstate == BS_TRACK)
        |=> built_o); // R9

endmodule

// File: tb/hovr_hist_mgr_bench.sv
module hovr_hist_mgr_bench;

    localparam int W   = 16;
    localparam int SH  = 3;
    localparam int BT  = 6;
    localparam int TPH = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         locked_i = 1'b0, sample_vld_i = 1'b0;
    logic [W-1:0] sample_i = '0;
    logic [1:0]   mode_i = 2'b00;
    logic         ref_switch_i = 1'b0, policy_i = 1'b0;
    logic         cmd_we_i = 1'b0;
    logic [1:0]   cmd_i = 2'b00;
    logic         tick_i = 1'b0;
    logic [W-1:0] active_hist_o;
    logic         avail_o, built_o;
    logic [1:0]   last_cmd_o;
    logic [7:0]   hours_o;

    always #10 clk = ~clk;

    hovr_hist_mgr #(
        .W (W), .AVG_SHIFT (SH), .BUILD_TICKS (BT), .TICKS_PER_HOUR (TPH)
    ) u_hovr_hist_mgr (
        .clk (clk), .rst_n (rst_n), .locked_i (locked_i),
        .sample_vld_i (sample_vld_i), .sample_i (sample_i), .mode_i (mode_i),
        .ref_switch_i (ref_switch_i), .policy_i (policy_i),
        .cmd_we_i (cmd_we_i), .cmd_i (cmd_i), .tick_i (tick_i),
        .active_hist_o (active_hist_o), .avail_o (avail_o), .built_o (built_o),
        .last_cmd_o (last_cmd_o), .hours_o (hours_o)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    logic [31:0] seed = 32'h1234_5678;

    // Behavioural model state
    int m_acc = 0, m_active = 0, m_backup = 0;
    bit m_has = 0, m_built = 0, m_avail = 0, m_bvalid = 0;
    int m_cnt = 0, m_last = 0, m_hrs = 0, m_tcnt = 0;

    always @(posedge clk) begin
        bit fl, rs, sw, rst_any, hold, upd, done;
        int s;
        int n_acc, n_active, n_backup, n_cnt, n_hrs, n_tcnt, n_last;
        bit n_has, n_built, n_avail, n_bvalid;
        if (!rst_n) begin
            m_acc = 0; m_active = 0; m_backup = 0; m_has = 0; m_built = 0;
            m_avail = 0; m_bvalid = 0; m_cnt = 0; m_last = 0; m_hrs = 0; m_tcnt = 0;
        end else begin
            fl      = cmd_we_i && cmd_i == 2'b11;
            rs      = cmd_we_i && cmd_i == 2'b10;
            sw      = ref_switch_i && !policy_i && !fl && !rs;
            rst_any = fl || rs || sw;
            hold    = (mode_i == 2'b10);
            s       = $signed(sample_i);
            upd     = locked_i && sample_vld_i && !rst_any;
            done    = !rst_any && m_has && !m_built && locked_i && tick_i && m_cnt == BT - 1;
            n_acc = m_acc; n_has = m_has; n_cnt = m_cnt; n_built = m_built;
            n_active = m_active; n_avail = m_avail; n_backup = m_backup;
            n_bvalid = m_bvalid; n_last = m_last; n_hrs = m_hrs; n_tcnt = m_tcnt;
            if (rst_any) begin n_acc = 0; n_has = 0; end
            else if (upd) begin
                n_acc = m_has ? m_acc + ((s - m_acc) >>> SH) : s;
                n_has = 1;
            end
            if (rst_any) begin n_cnt = 0; n_built = 0; end
            else if (done) begin n_cnt = 0; n_built = 1; end
            else if (m_has && !m_built && locked_i && tick_i) n_cnt = m_cnt + 1;
            if (fl || sw) begin n_active = 0; n_avail = 0; end
            else if (rs) begin n_active = m_backup; n_avail = m_bvalid; end
            else if (done) begin n_active = m_acc; n_avail = 1; end
            else if (m_built && !hold) n_active = m_acc;
            if (cmd_we_i && cmd_i == 2'b01) begin n_backup = m_active; n_bvalid = m_avail; end
            if (cmd_we_i) n_last = cmd_i;
            if (!hold) begin n_hrs = 0; n_tcnt = 0; end
            else if (tick_i) begin
                if (m_tcnt == TPH - 1) begin
                    n_tcnt = 0;
                    if (m_hrs < 255) n_hrs = m_hrs + 1;
                end else n_tcnt = m_tcnt + 1;
            end
            m_acc = n_acc; m_has = n_has; m_cnt = n_cnt; m_built = n_built;
            m_active = n_active; m_avail = n_avail; m_backup = n_backup;
            m_bvalid = n_bvalid; m_last = n_last; m_hrs = n_hrs; m_tcnt = n_tcnt;
        end
    end

    task automatic chk(string name, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, name, act, exp);
        end
    endtask

    // Compare every output one cycle after its cause, away from the rising edge
    always @(negedge clk) begin
        chk("active_hist_o", int'(active_hist_o), m_active & 16'hFFFF);
        chk("avail_o", int'(avail_o), int'(m_avail));
        chk("built_o", int'(built_o), int'(m_built));
        chk("last_cmd_o", int'(last_cmd_o), m_last);
        chk("hours_o", int'(hours_o), (mode_i == 2'b10) ? m_hrs : 0);
    end

    task automatic nxt();
        @(negedge clk);
        #2;
    endtask

    // Run n cycles with a tick every tdiv cycles and fresh samples when vld
    task automatic run(int n, int tdiv, bit vld);
        for (int i = 0; i < n; i++) begin
            seed         = seed * 32'd1103515245 + 32'd12345;
            sample_i     = seed[30:15];
            sample_vld_i = vld;
            tick_i       = (tdiv > 0) && (i % tdiv == 0);
            nxt();
        end
        tick_i = 1'b0;
        sample_vld_i = 1'b0;
    endtask

    task automatic cmd(logic [1:0] c);
        cmd_i = c; cmd_we_i = 1'b1;
        nxt();
        cmd_we_i = 1'b0;
    endtask

    task automatic rswitch(logic pol);
        policy_i = pol; ref_switch_i = 1'b1;
        nxt();
        ref_switch_i = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        nxt(); nxt(); nxt();
        rst_n = 1'b1;
        nxt();
        chk("R1 reset active", int'(active_hist_o), 0);
        // Samples while unlocked must not enter the accumulator
        cur_req = "R2";
        run(5, 1, 1'b1);
        locked_i = 1'b1; mode_i = 2'b01;
        run(30, 2, 1'b1);
        cur_req = "R3";
        chk("R3 built after build ticks", int'(built_o), 1);
        cur_req = "R4";
        run(15, 1, 1'b1);
        // Negative samples stress the arithmetic shift
        cur_req = "R2";
        for (int k = 0; k < 8; k++) begin
            sample_i = 16'h8000 + 16'(k * 3); sample_vld_i = 1'b1;
            nxt();
        end
        sample_vld_i = 1'b0;
        cur_req = "R4";
        locked_i = 1'b0; mode_i = 2'b10;
        run(14, 1, 1'b0);
        cur_req = "R10";
        chk("R10 hours in hold", int'(hours_o), 4);
        mode_i = 2'b01; locked_i = 1'b1;
        #1;
        chk("R10 hours leave hold", int'(hours_o), 0);
        nxt();
        cur_req = "R5";
        cmd(2'b01);
        run(6, 0, 1'b1);
        cur_req = "R7";
        cmd(2'b11);
        chk("R7 flush active", int'(active_hist_o), 0);
        run(3, 0, 1'b0);
        cur_req = "R6";
        cmd(2'b10);
        run(4, 0, 1'b0);
        run(20, 1, 1'b1);
        cur_req = "R8";
        cmd(2'b00);
        chk("R8 last cmd none", int'(last_cmd_o), 0);
        run(4, 1, 1'b1);
        cur_req = "R9";
        rswitch(1'b1);
        run(4, 1, 1'b1);
        rswitch(1'b0);
        run(3, 0, 1'b0);
        // Switch and restore in the same cycle: restore takes precedence
        policy_i = 1'b0; ref_switch_i = 1'b1;
        cmd(2'b10);
        ref_switch_i = 1'b0;
        run(20, 1, 1'b1);
        cur_req = "R10";
        locked_i = 1'b0; mode_i = 2'b10;
        run(800, 1, 1'b0);
        chk("R10 hours saturate", int'(hours_o), 255);
        mode_i = 2'b00;
        run(3, 1, 1'b0);
        mode_i = 2'b10;
        run(4, 1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule